// File: doc/BRIEF.md
# Dual I/O Serial Flash Read Engine

Host-side read engine for a serial NOR flash that runs the dual-I/O fast read transaction. A user request gives a 24-bit start address, a byte count and a continuous-mode enable. The engine opens chip select and shifts out the opcode on one line, then sends the address and mode byte two bits per clock. It then releases both data lines and assembles the returned bits into bytes, one `rvalid_o` pulse per byte.

The engine keeps a flag that tracks whether the flash is latched in continuous read mode. While the flag is set, the next transaction leaves out the 8-clock opcode and starts at the first address clock, which shortens each random access by eight serial clocks. A separate request sends a mode-reset transaction: sixteen clocks of ones on IO0. It clears the flag so that the next read sends the opcode again. SCLK is the system clock divided by two, in SPI mode 0.

Top module: `dio_flash_reader`

## Requirements
- R1: After reset and whenever idle: `cs_no`=1, `sclk_o`=0, `busy_o`=0, `rvalid_o`=0, `io0_oe_o`=0 and `io1_oe_o`=0.
- R2: While `cs_no` is low, SCLK alternates one system cycle low, then one high, starting low. Data outputs and enables change only at the falling edge or at the start of a transaction. SCLK is low whenever chip select is high.
- R3: A full transaction starts with the opcode 0xBB, MSB first on IO0, over 8 clocks. IO1 is not driven during these clocks.
- R4: The 24-bit address follows in 12 clocks and the mode byte follows in 4 clocks, both with IO1 and IO0 driven. In each clock IO1 carries the higher bit of the pair (address bit 23 and bit 22 first). The mode byte is 0x20 when `cont_en_i`=1 and 0x00 otherwise.
- R5: Both lines are released at the falling edge that ends the last mode clock. Each byte takes 4 clocks, MSB first, with IO1 holding the higher bit of each pair. `rdata_o` is valid with a one-cycle `rvalid_o` pulse in the system cycle after the high half of the byte's 4th clock.
- R6: After a read with `cont_en_i`=1, the next read omits the opcode. Its first clock carries address bits 23:22.
- R7: After a read with `cont_en_i`=0, the next read starts with the full opcode.
- R8: A mode-reset request (`mrst_i`) sends 16 clocks with IO0=1 and IO1 not driven. After it, the next read sends the opcode.
- R9: `start_i` and `mrst_i` are ignored while `busy_o` is high. Chip select stays high for at least 2 system cycles between transactions.
- R10: A byte count of 0 runs the opcode, address and mode phases with no data clocks and no `rvalid_o`. The continuous flag still follows `cont_en_i`.
- R11: If `mrst_i` and `start_i` are both high in an idle cycle, the mode-reset transaction runs and the read request is dropped.
- R12: `busy_o` rises in the cycle after a start is accepted. It stays high for 2×(serial clocks)+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request, sampled while idle |
| addr_i | input | ADDR_W | Start address of the read |
| len_i | input | LEN_W | Number of bytes to read |
| cont_en_i | input | 1 | Leave the flash in continuous read mode after this read |
| mrst_i | input | 1 | Request a mode-reset transaction |
| rdata_o | output | 8 | Received byte |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| busy_o | output | 1 | Transaction or inter-transaction gap in progress |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low chip select |
| io0_o | output | 1 | IO0 output value |
| io0_oe_o | output | 1 | IO0 output enable |
| io0_i | input | 1 | IO0 input value |
| io1_o | output | 1 | IO1 output value |
| io1_oe_o | output | 1 | IO1 output enable |
| io1_i | input | 1 | IO1 input value |

## Verification
A wrong continuous flag shows within the first eight serial clocks of the next read. The opcode is either missing or extra, so the responder decodes a shifted address and the serial clock count at chip-select rise is off by eight. A wrong phase counter shows as a wrong clock count or a wrong address at the end of the same transaction. An early or late release of the lines shows on the first data clock as an enable still high while the responder drives. A bad assembly of received bytes shows in the cycle-by-cycle comparison of `rvalid_o` and `rdata_o` on the first byte.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DATA,
    PH_MRST,
    PH_GAP
  } phase_e;

  localparam logic [7:0] CMD_DIO   = 8'hBB;
  localparam logic [7:0] MODE_CONT = 8'h20;  // bits 5:4 = 2'b10
  localparam logic [7:0] MODE_NORM = 8'h00;
  localparam int CMD_CLKS   = 8;
  localparam int MODE_CLKS  = 4;
  localparam int MRST_CLKS  = 16;
  localparam int PAIR_CLKS  = 4;
  localparam int GAP_CYC    = 2;
  localparam int IDX_W      = 5;
endpackage

// File: rtl/dio_sclk_gen.sv
module dio_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic hi_end_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else if (run_i) sclk_q <= ~sclk_q;
    else sclk_q <= 1'b0;
  end

  assign sclk_o   = sclk_q;
  // edge that ends a high half: sample point and falling edge
  assign hi_end_o = run_i & sclk_q;
endmodule

// File: rtl/dio_tx_mux.sv
module dio_tx_mux
  import dio_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  phase_e             phase_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         mode_i,
  output logic               io0_o,
  output logic               io1_o,
  output logic               io0_oe_o,
  output logic               io1_oe_o
);
  logic [ADDR_W-1:0] a_sh;
  logic [7:0]        m_sh;
  logic [7:0]        c_sh;

  always_comb begin
    a_sh     = addr_i << {idx_i, 1'b0};
    m_sh     = mode_i << {idx_i, 1'b0};
    c_sh     = CMD_DIO << idx_i;
    io0_o    = 1'b0;
    io1_o    = 1'b0;
    io0_oe_o = 1'b0;
    io1_oe_o = 1'b0;
    case (phase_i)
      PH_CMD: begin
        io0_o    = c_sh[7];
        io0_oe_o = 1'b1;
      end
      PH_ADDR: begin
        io1_o    = a_sh[ADDR_W-1];
        io0_o    = a_sh[ADDR_W-2];
        io0_oe_o = 1'b1;
        io1_oe_o = 1'b1;
      end
      PH_MODE: begin
        io1_o    = m_sh[7];
        io0_o    = m_sh[6];
        io0_oe_o = 1'b1;
        io1_oe_o = 1'b1;
      end
      PH_MRST: begin
        io0_o    = 1'b1;
        io0_oe_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dio_rx_deser.sv
module dio_rx_deser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       last_i,
  input  logic       io0_i,
  input  logic       io1_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  logic [5:0] sh_q;
  logic [7:0] data_q;
  logic       valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (take_i) begin
        sh_q <= {sh_q[3:0], io1_i, io0_i};
        if (last_i) begin
          data_q  <= {sh_q, io1_i, io0_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dio_seq.sv
module dio_seq
  import dio_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               cont_en_i,
  input  logic               mrst_i,
  input  logic               hi_end_i,
  output phase_e             phase_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [7:0]         mode_o,
  output logic               take_o,
  output logic               last_o
);
  localparam int ADDR_CLKS = ADDR_W / 2;
  localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_CLKS - 1);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_CLKS - 1);
  localparam logic [IDX_W-1:0] MODE_LAST = IDX_W'(MODE_CLKS - 1);
  localparam logic [IDX_W-1:0] PAIR_LAST = IDX_W'(PAIR_CLKS - 1);
  localparam logic [IDX_W-1:0] MRST_LAST = IDX_W'(MRST_CLKS - 1);
  localparam logic [IDX_W-1:0] GAP_LAST  = IDX_W'(GAP_CYC - 1);

  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic [LEN_W-1:0]   left_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               cont_en_q;
  logic               latched_q;  // flash believed to be in continuous mode

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      cont_en_q <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          idx_q <= '0;
          if (mrst_i) begin
            phase_q <= PH_MRST;
          end else if (start_i) begin
            addr_q    <= addr_i;
            left_q    <= len_i;
            cont_en_q <= cont_en_i;
            phase_q   <= latched_q ? PH_ADDR : PH_CMD;
          end
        end
        PH_CMD: if (hi_end_i) begin
          if (idx_q == CMD_LAST) begin
            idx_q   <= '0;
            phase_q <= PH_ADDR;
          end else idx_q <= idx_q + 1'b1;
        end
        PH_ADDR: if (hi_end_i) begin
          if (idx_q == ADDR_LAST) begin
            idx_q   <= '0;
            phase_q <= PH_MODE;
          end else idx_q <= idx_q + 1'b1;
        end
        PH_MODE: if (hi_end_i) begin
          if (idx_q == MODE_LAST) begin
            idx_q <= '0;
            if (left_q == '0) begin
              phase_q   <= PH_GAP;
              latched_q <= cont_en_q;
            end else phase_q <= PH_DATA;
          end else idx_q <= idx_q + 1'b1;
        end
        PH_DATA: if (hi_end_i) begin
          if (idx_q == PAIR_LAST) begin
            idx_q  <= '0;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
              phase_q   <= PH_GAP;
              latched_q <= cont_en_q;
            end
          end else idx_q <= idx_q + 1'b1;
        end
        PH_MRST: if (hi_end_i) begin
          if (idx_q == MRST_LAST) begin
            idx_q     <= '0;
            phase_q   <= PH_GAP;
            latched_q <= 1'b0;
          end else idx_q <= idx_q + 1'b1;
        end
        PH_GAP: begin
          if (idx_q == GAP_LAST) begin
            idx_q   <= '0;
            phase_q <= PH_IDLE;
          end else idx_q <= idx_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign addr_o  = addr_q;
  assign mode_o  = cont_en_q ? MODE_CONT : MODE_NORM;
  assign take_o  = hi_end_i && (phase_q == PH_DATA);
  assign last_o  = take_o && (idx_q == PAIR_LAST);
endmodule

// File: rtl/dio_flash_reader.sv
module dio_flash_reader
  import dio_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               cont_en_i,
  input  logic               mrst_i,
  output logic [7:0]         rdata_o,
  output logic               rvalid_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               io0_o,
  output logic               io0_oe_o,
  input  logic               io0_i,
  output logic               io1_o,
  output logic               io1_oe_o,
  input  logic               io1_i
);
  phase_e             phase;
  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  addr_cur;
  logic [7:0]         mode_cur;
  logic               run;
  logic               hi_end;
  logic               take;
  logic               last;

  assign run    = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_MODE) ||
                  (phase == PH_DATA) || (phase == PH_MRST);
  assign cs_no  = ~run;
  assign busy_o = (phase != PH_IDLE);

  dio_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .len_i     (len_i),
    .cont_en_i (cont_en_i),
    .mrst_i    (mrst_i),
    .hi_end_i  (hi_end),
    .phase_o   (phase),
    .idx_o     (idx),
    .addr_o    (addr_cur),
    .mode_o    (mode_cur),
    .take_o    (take),
    .last_o    (last)
  );

  dio_sclk_gen u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sclk_o   (sclk_o),
    .hi_end_o (hi_end)
  );

  dio_tx_mux #(.ADDR_W(ADDR_W)) u_tx (
    .phase_i  (phase),
    .idx_i    (idx),
    .addr_i   (addr_cur),
    .mode_i   (mode_cur),
    .io0_o    (io0_o),
    .io1_o    (io1_o),
    .io0_oe_o (io0_oe_o),
    .io1_oe_o (io1_oe_o)
  );

  dio_rx_deser u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .last_i  (last),
    .io0_i   (io0_i),
    .io1_i   (io1_i),
    .data_o  (rdata_o),
    .valid_o (rvalid_o)
  );
endmodule

// File: rtl/dio_flash_reader_chk.sv
module dio_flash_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic cs_no,
  input logic sclk_o,
  input logic io0_o,
  input logic io1_o,
  input logic io0_oe_o,
  input logic io1_oe_o,
  input logic rvalid_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o && !io0_oe_o && !io1_oe_o && !rvalid_o)); // R1
  AST_SCLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R2
  AST_SCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !sclk_o) |=> sclk_o); // R2
  AST_TX_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable({io0_o, io1_o, io0_oe_o, io1_oe_o})); // R2
  AST_IO1_WITH_IO0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io1_oe_o |-> io0_oe_o); // R4
  AST_RVALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5
  AST_RVALID_IN_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o); // R5
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no); // R9
  AST_BUSY_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R12
endmodule

bind dio_flash_reader dio_flash_reader_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .cs_no    (cs_no),
  .sclk_o   (sclk_o),
  .io0_o    (io0_o),
  .io1_o    (io1_o),
  .io0_oe_o (io0_oe_o),
  .io1_oe_o (io1_oe_o),
  .rvalid_o (rvalid_o)
);

// File: tb/dio_flash_reader_tb_top.sv
`timescale 1ns/1ps
module dio_flash_reader_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       cs;
    logic       sclk;
    logic       busy;
    logic       rv;
    logic [7:0] rd;
  } exp_t;

  typedef struct packed {
    logic        mrst;
    logic [23:0] addr;
    logic [15:0] len;
    logic        cont;
    logic        cmd;
  } fx_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] len = '0;
  logic cont_en = 1'b0;
  logic mrst = 1'b0;
  logic [7:0] rdata;
  logic rvalid, busy, sclk, cs_n, io0_o, io0_oe, io1_o, io1_oe;
  logic io0_in = 1'b0;
  logic io1_in = 1'b0;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit exp_latched = 1'b0;
  exp_t exp_q[$];
  fx_t  fx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_flash_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .cont_en_i(cont_en), .mrst_i(mrst), .rdata_o(rdata), .rvalid_o(rvalid),
    .busy_o(busy), .sclk_o(sclk), .cs_no(cs_n), .io0_o(io0_o), .io0_oe_o(io0_oe),
    .io0_i(io0_in), .io1_o(io1_o), .io1_oe_o(io1_oe), .io1_i(io1_in)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle model: one entry per system cycle, sampled at negedge
  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e, g;
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else e = '{cs: 1'b1, sclk: 1'b0, busy: 1'b0, rv: 1'b0, rd: 8'h00};
      g = '{cs: cs_n, sclk: sclk, busy: busy, rv: rvalid, rd: (rvalid ? rdata : 8'h00)};
      chk(g == e, "R2 R5 R9 R12 cycle model", 32'(g), 32'(e));
    end
  end

  // behavioural flash responder
  bit prev_cs = 1'b1, prev_sclk = 1'b0;
  bit f_latched = 1'b0, f_skip = 1'b0, f_ones = 1'b0;
  bit bad_cmd_oe = 1'b0, bad_addr_oe = 1'b0, bad_data_oe = 1'b0;
  int f_n = 0;
  logic [7:0]  f_cmd = '0;
  logic [23:0] f_addr = '0;
  logic [7:0]  f_mode = '0;

  always @(negedge clk) begin
    int cl;
    cl = f_skip ? 0 : 8;
    if (prev_cs && !cs_n) begin
      f_n = 0; f_cmd = '0; f_addr = '0; f_mode = '0; f_ones = 1'b1;
      f_skip = f_latched;
      bad_cmd_oe = 0; bad_addr_oe = 0; bad_data_oe = 0;
      cl = f_skip ? 0 : 8;
    end
    if (!cs_n && sclk && !prev_sclk) begin
      f_ones = f_ones && io0_oe && io0_o && !io1_oe;
      if (f_n < cl) begin
        f_cmd = {f_cmd[6:0], io0_o};
        if (!io0_oe || io1_oe) bad_cmd_oe = 1;
      end else if (f_n < cl + 12) begin
        f_addr = {f_addr[21:0], io1_o, io0_o};
        if (!io0_oe || !io1_oe) bad_addr_oe = 1;
      end else if (f_n < cl + 16) begin
        f_mode = {f_mode[5:0], io1_o, io0_o};
        if (!io0_oe || !io1_oe) bad_addr_oe = 1;
      end else begin
        if (io0_oe || io1_oe) bad_data_oe = 1;
      end
      f_n++;
    end
    if (!cs_n && !sclk && prev_sclk && f_n >= cl + 16 && (f_skip || f_cmd == 8'hBB)) begin
      int k;
      logic [7:0] b;
      if (io0_oe || io1_oe) bad_data_oe = 1;
      k = f_n - (cl + 16);
      b = pat(f_addr + 24'(k / 4));
      io1_in = b[7 - 2 * (k % 4)];
      io0_in = b[6 - 2 * (k % 4)];
    end
    if (!prev_cs && cs_n) begin
      fx_t r;
      io0_in = 1'b0; io1_in = 1'b0;
      if (fx_q.size() == 0) begin
        chk(1'b0, "R9 unexpected transaction", 32'(f_n), 32'd0);
      end else begin
        r = fx_q.pop_front();
        if (f_n == 16 && f_ones) begin
          chk(r.mrst == 1'b1, "R8 R11 mode reset seen where read expected", 32'(r.mrst), 32'd1);
          f_latched = 1'b0;
        end else begin
          chk(r.mrst == 1'b0, "R8 R11 read seen where mode reset expected", 32'(r.mrst), 32'd0);
          chk(f_n == cl + 16 + 4 * int'(r.len), "R10 R12 serial clock count", 32'(f_n), 32'(cl + 16 + 4 * int'(r.len)));
          chk(f_skip == !r.cmd, "R6 R7 opcode presence", 32'(f_skip), 32'(!r.cmd));
          chk(f_addr == r.addr, "R4 address", 32'(f_addr), 32'(r.addr));
          chk(f_mode == (r.cont ? 8'h20 : 8'h00), "R4 mode byte", 32'(f_mode), r.cont ? 32'h20 : 32'h00);
          if (!f_skip) chk(f_cmd == 8'hBB, "R3 opcode", 32'(f_cmd), 32'hBB);
          chk(!bad_cmd_oe, "R3 enables during opcode", 32'(bad_cmd_oe), 32'd0);
          chk(!bad_addr_oe, "R4 enables during address and mode", 32'(bad_addr_oe), 32'd0);
          chk(!bad_data_oe, "R5 lines released for data", 32'(bad_data_oe), 32'd0);
          f_latched = (f_mode[5:4] == 2'b10);
        end
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || busy);
  endtask

  task automatic push_txn(input bit is_mrst, input logic [23:0] a, input int l, input bit c);
    int cl, n, d;
    exp_t e;
    cl = (is_mrst || exp_latched) ? 0 : 8;
    n  = is_mrst ? 16 : cl + 16 + 4 * l;
    d  = cl + 16;
    for (int j = 0; j < 2 * n + 2; j++) begin
      e = '{cs: (j >= 2 * n), sclk: (j < 2 * n) && (j % 2 == 1), busy: 1'b1, rv: 1'b0, rd: 8'h00};
      if (!is_mrst && j % 2 == 0 && j / 2 >= d + 4 && (j / 2 - d) % 4 == 0) begin
        e.rv = 1'b1;
        e.rd = pat(a + 24'((j / 2 - d) / 4 - 1));
      end
      exp_q.push_back(e);
    end
    fx_q.push_back('{mrst: is_mrst, addr: a, len: 16'(l), cont: c, cmd: !exp_latched});
    exp_latched = is_mrst ? 1'b0 : c;
  endtask

  task automatic do_read(input logic [23:0] a, input int l, input bit c);
    wait_idle();
    #1;
    start = 1'b1; addr = a; len = 16'(l); cont_en = c;
    push_txn(1'b0, a, l, c);
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic do_mrst(input bit with_start);
    wait_idle();
    #1;
    mrst = 1'b1; start = with_start; addr = 24'hABCDEF; len = 16'd3; cont_en = 1'b1;
    push_txn(1'b1, 24'h0, 0, 1'b0);
    @(negedge clk); #1 begin mrst = 1'b0; start = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R12 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1 && sclk == 0 && busy == 0 && rvalid == 0 && io0_oe == 0 && io1_oe == 0,
        "R1 reset state", {26'd0, cs_n, sclk, busy, rvalid, io0_oe, io1_oe}, 32'h20);
    mon_en = 1'b1;

    do_read(24'h012345, 3, 1'b0);   // R3 R4 R5 full opcode
    do_read(24'h00A0F0, 2, 1'b1);   // enters continuous mode
    do_read(24'h123456, 2, 1'b0);   // R6 opcode skipped
    do_read(24'h0000FF, 1, 1'b0);   // R7 opcode back
    do_read(24'hFFFFFE, 4, 1'b1);   // address wrap in pattern
    do_mrst(1'b0);                  // R8 clears latched state
    do_read(24'h400000, 2, 1'b1);   // R8 opcode present after reset
    do_read(24'h777777, 3, 1'b1);   // R6 skipped; R9 requests while busy
    repeat (6) @(negedge clk);
    #1 begin start = 1'b1; mrst = 1'b1; addr = 24'h5A5A5A; len = 16'd9; end
    @(negedge clk); #1 begin start = 1'b0; mrst = 1'b0; end
    do_read(24'h111111, 0, 1'b0);   // R10 zero length, no opcode
    do_read(24'h222222, 1, 1'b1);   // R10 flag cleared: opcode present
    do_mrst(1'b1);                  // R11 mode reset wins over start
    do_read(24'h333333, 2, 1'b0);   // R11 opcode present afterwards
    do_mrst(1'b0);                  // R8 reset while not latched
    do_read(24'h000000, 1, 1'b0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(fx_q.size() == 0, "R9 all expected transactions seen, no extras", 32'(fx_q.size()), 32'd0);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 R9 idle after last transaction", {30'd0, cs_n, busy}, 32'h2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule